// File: doc/BRIEF.md
# PC-relative branch decode unit

This unit looks at one 16-bit instruction word for a small 32-bit processor and decides whether it is a short conditional branch. If it is, the unit decides whether the branch is taken and computes where it goes. A branch word carries a 2-bit form prefix, a 4-bit condition code and a 10-bit signed displacement. The displacement counts halfwords, so the byte offset is the displacement times two, and the offset is added to the address of the branch itself. The reach is therefore -1024 to +1022 bytes.

The condition is judged against three comparison flags that an earlier compare instruction left behind: equal, signed less-than and unsigned less-than. Nine condition codes are defined. The other seven codes in the branch form are reported as illegal and are never taken. The unit also gives the sequential next address, which is the branch address plus 2. Every output is captured in a register on a clock edge where the valid strobe is high, and holds its value otherwise. Results appear one cycle after the strobe.

Condition codes (instruction bits 13:10): 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 to 15 reserved.

Top module: `brdec_unit`

## Requirements
- R1: While reset is held, and on the first edge after it, every output reads zero.
- R2: `out_form` is 1 exactly when bits 15:14 of the captured word are binary 11.
- R3: `out_target` equals the captured address plus the sign-extended bits 9:0 shifted left by one, modulo 2^32. For example, displacement 4 gives address+8.
- R4: `out_seq_pc` equals the captured address plus 2, modulo 2^32.
- R5: For branch-form words with codes 0 to 8, `out_taken` follows the condition table above. Greater means neither less nor equal, and less-or-equal means less or equal. The flags are `flag_eq`, `flag_lt` (signed) and `flag_ltu` (unsigned).
- R6: For branch-form words with codes 9 to 15, `out_illegal` is 1 and `out_taken` is 0, whatever the flags are.
- R7: For a word outside the branch form, `out_taken` and `out_illegal` are both 0.
- R8: The outputs change only on the edge after a cycle with `in_valid` high. With `in_valid` low, they keep their values even when the other inputs change.
- R9: Displacement 0x1FF gives an offset of +1022, displacement 0x200 gives -1024, and a target or sequential address that passes address zero wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word and address are valid this cycle |
| instr | input | 16 | Instruction word |
| instr_pc | input | 32 | Byte address of the instruction |
| flag_eq | input | 1 | Latched equal flag |
| flag_lt | input | 1 | Latched signed less-than flag |
| flag_ltu | input | 1 | Latched unsigned less-than flag |
| out_form | output | 1 | Word is in the branch form |
| out_taken | output | 1 | Branch is taken |
| out_illegal | output | 1 | Branch form with a reserved code |
| out_target | output | 32 | Branch destination address |
| out_seq_pc | output | 32 | Address of the following halfword |

## Verification
Two things can land in the same cycle: the reserved-code check and the condition evaluation. Both read the same 4-bit field. The bench provokes this by sending reserved codes with all three flags set, and separately with all three clear. It then checks that the taken flag stays low, that the illegal flag rises, and that the target is still computed. The other overlap is address arithmetic crossing zero while a condition is true. Here the taken flag and the wrapped target must both be correct in the same captured result.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    localparam int INSN_W = 16;
    localparam int OP_W   = 4;
    localparam int DISP_W = 10;

    typedef enum logic [OP_W-1:0] {
        BR_EQ  = 4'd0,
        BR_NE  = 4'd1,
        BR_LT  = 4'd2,
        BR_GT  = 4'd3,
        BR_LTU = 4'd4,
        BR_GTU = 4'd5,
        BR_GE  = 4'd6,
        BR_LE  = 4'd7,
        BR_GEU = 4'd8
    } br_op_e;

    typedef struct packed {
        logic              eq;
        logic              lt;
        logic              ltu;
    } cmp_flags_t;

    typedef struct packed {
        logic              form;
        logic [OP_W-1:0]   op;
        logic [DISP_W-1:0] disp;
    } br_fields_t;

endpackage

// File: rtl/brdec_fields.sv
module brdec_fields
    import brdec_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output br_fields_t        fields
);
    localparam int PFX_HI = INSN_W - 1;
    localparam int PFX_LO = INSN_W - 2;
    localparam int OP_LO  = PFX_LO - OP_W;

    always_comb begin
        fields.form = (instr[PFX_HI:PFX_LO] == 2'b11);
        fields.op   = instr[PFX_LO-1:OP_LO];
        fields.disp = instr[DISP_W-1:0];
    end
endmodule

// File: rtl/brdec_cond.sv
module brdec_cond
    import brdec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  cmp_flags_t      flags,
    output logic            cond_true,
    output logic            reserved
);
    logic gt_s;
    logic gt_u;

    always_comb begin
        gt_s      = !flags.lt  && !flags.eq;
        gt_u      = !flags.ltu && !flags.eq;
        cond_true = 1'b0;
        reserved  = 1'b0;
        unique case (br_op_e'(op))
            BR_EQ:   cond_true = flags.eq;
            BR_NE:   cond_true = !flags.eq;
            BR_LT:   cond_true = flags.lt;
            BR_GT:   cond_true = gt_s;
            BR_LTU:  cond_true = flags.ltu;
            BR_GTU:  cond_true = gt_u;
            BR_GE:   cond_true = !flags.lt;
            BR_LE:   cond_true = flags.lt || flags.eq;
            BR_GEU:  cond_true = !flags.ltu;
            default: reserved  = 1'b1;
        endcase
    end
endmodule

// File: rtl/brdec_target.sv
module brdec_target #(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 10,
    parameter int STEP_BYTES = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_pc
);
    localparam int OFF_W = DISP_W + 1;
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        target = pc + offset;
        seq_pc = pc + ADDR_W'(STEP_BYTES);
    end
endmodule

// File: rtl/brdec_unit.sv
module brdec_unit
    import brdec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] instr_pc,
    input  logic              flag_eq,
    input  logic              flag_lt,
    input  logic              flag_ltu,
    output logic              out_form,
    output logic              out_taken,
    output logic              out_illegal,
    output logic [ADDR_W-1:0] out_target,
    output logic [ADDR_W-1:0] out_seq_pc
);
    br_fields_t        fields;
    cmp_flags_t        flags;
    logic              cond_true;
    logic              reserved;
    logic [ADDR_W-1:0] target_d;
    logic [ADDR_W-1:0] seq_d;
    logic              taken_d;
    logic              illegal_d;

    assign flags = '{eq: flag_eq, lt: flag_lt, ltu: flag_ltu};

    brdec_fields u_fields (
        .instr  (instr),
        .fields (fields)
    );

    brdec_cond u_cond (
        .op        (fields.op),
        .flags     (flags),
        .cond_true (cond_true),
        .reserved  (reserved)
    );

    brdec_target #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_target (
        .pc     (instr_pc),
        .disp   (fields.disp),
        .target (target_d),
        .seq_pc (seq_d)
    );

    always_comb begin
        taken_d   = fields.form && !reserved && cond_true;
        illegal_d = fields.form && reserved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_form    <= 1'b0;
            out_taken   <= 1'b0;
            out_illegal <= 1'b0;
            out_target  <= '0;
            out_seq_pc  <= '0;
        end else if (in_valid) begin
            out_form    <= fields.form;
            out_taken   <= taken_d;
            out_illegal <= illegal_d;
            out_target  <= target_d;
            out_seq_pc  <= seq_d;
        end
    end
endmodule

// File: rtl/brdec_unit_chk.sv
module brdec_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       instr,
    input logic [ADDR_W-1:0] instr_pc,
    input logic              out_form,
    input logic              out_taken,
    input logic              out_illegal,
    input logic [ADDR_W-1:0] out_target,
    input logic [ADDR_W-1:0] out_seq_pc
);
    localparam int EXT_W = ADDR_W - 11;

    p_taken_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> out_form);

    p_illegal_never_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_form && !out_taken));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_target) && $stable(out_seq_pc)
                       && $stable(out_taken) && $stable(out_form)
                       && $stable(out_illegal)));

    p_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_form == ($past(instr[15:14]) == 2'b11)));

    p_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_seq_pc == $past(instr_pc) + ADDR_W'(2)));

    p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_target == $past(instr_pc)
                      + {{EXT_W{$past(instr[9])}}, $past(instr[9:0]), 1'b0}));
endmodule

bind brdec_unit brdec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .instr_pc    (instr_pc),
    .out_form    (out_form),
    .out_taken   (out_taken),
    .out_illegal (out_illegal),
    .out_target  (out_target),
    .out_seq_pc  (out_seq_pc)
);

// File: tb/brdec_unit_test.sv
module brdec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] instr_pc = '0;
    logic        flag_eq = 1'b0;
    logic        flag_lt = 1'b0;
    logic        flag_ltu = 1'b0;
    logic        out_form;
    logic        out_taken;
    logic        out_illegal;
    logic [31:0] out_target;
    logic [31:0] out_seq_pc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    brdec_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .instr_pc(instr_pc), .flag_eq(flag_eq), .flag_lt(flag_lt),
        .flag_ltu(flag_ltu), .out_form(out_form), .out_taken(out_taken),
        .out_illegal(out_illegal), .out_target(out_target),
        .out_seq_pc(out_seq_pc)
    );

    // {instr, pc, {eq,lt,ltu}, taken, illegal}
    localparam int NV = 21;
    localparam logic [52:0] VEC [NV] = '{
        {16'hC004, 32'h0000_1000, 3'b100, 1'b1, 1'b0},  // R5 eq taken, R3 +8
        {16'hC020, 32'h0000_1000, 3'b010, 1'b0, 1'b0},  // R5 eq not
        {16'hC7E0, 32'h0000_2000, 3'b000, 1'b1, 1'b0},  // R5 ne
        {16'hC420, 32'h0000_2000, 3'b100, 1'b0, 1'b0},
        {16'hC820, 32'h0000_3000, 3'b010, 1'b1, 1'b0},  // R5 lt
        {16'hCBE0, 32'h0000_3000, 3'b100, 1'b0, 1'b0},
        {16'hCC20, 32'h0000_4000, 3'b000, 1'b1, 1'b0},  // R5 gt
        {16'hCFE0, 32'h0000_4000, 3'b100, 1'b0, 1'b0},
        {16'hD020, 32'h0000_5000, 3'b001, 1'b1, 1'b0},  // R5 ltu
        {16'hD3E0, 32'h0000_5000, 3'b010, 1'b0, 1'b0},
        {16'hD420, 32'h0000_6000, 3'b000, 1'b1, 1'b0},  // R5 gtu
        {16'hD7E0, 32'h0000_6000, 3'b001, 1'b0, 1'b0},
        {16'hD820, 32'h0000_7000, 3'b100, 1'b1, 1'b0},  // R5 ge
        {16'hDBE0, 32'h0000_7000, 3'b010, 1'b0, 1'b0},
        {16'hDC20, 32'h0000_8000, 3'b100, 1'b1, 1'b0},  // R5 le
        {16'hDFE0, 32'h0000_8000, 3'b000, 1'b0, 1'b0},
        {16'hE020, 32'h0000_9000, 3'b010, 1'b1, 1'b0},  // R5 geu
        {16'hE3E0, 32'h0000_9000, 3'b001, 1'b0, 1'b0},
        {16'hE420, 32'h0000_A000, 3'b111, 1'b0, 1'b1},  // R6 reserved, flags set
        {16'hFC20, 32'h0000_A000, 3'b000, 1'b0, 1'b1},  // R6 reserved, flags clear
        {16'h8004, 32'h0000_B000, 3'b111, 1'b0, 1'b0}   // R7 other form
    };

    function automatic logic [31:0] ref_target(logic [31:0] pc, logic [15:0] w);
        logic [31:0] off;
        off = {{21{w[9]}}, w[9:0], 1'b0};
        return pc + off;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] w, logic [31:0] pc, logic [2:0] f);
        @(negedge clk);
        instr    = w;
        instr_pc = pc;
        {flag_eq, flag_lt, flag_ltu} = f;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_all(logic [15:0] w, logic [31:0] pc, bit tk, bit il);
        logic [31:0] t;
        t = ref_target(pc, w);
        chk(out_form == (w[15:14] == 2'b11), "R2 form", 32'(out_form), 32'(w[15:14] == 2'b11));
        chk(out_taken == tk, "R5/R6/R7 taken", 32'(out_taken), 32'(tk));
        chk(out_illegal == il, "R6/R7 illegal", 32'(out_illegal), 32'(il));
        chk(out_target == t, "R3 target", out_target, t);
        chk(out_seq_pc == pc + 32'd2, "R4 seq", out_seq_pc, pc + 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_form == 0 && out_taken == 0 && out_illegal == 0, "R1 flags",
            32'({out_form, out_taken, out_illegal}), 32'd0);
        chk(out_target == 0 && out_seq_pc == 0, "R1 addrs", out_target | out_seq_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_target == 0 && out_taken == 0, "R1 after release",
            out_target, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][52:37], VEC[i][36:5], VEC[i][4:2]);
            check_all(VEC[i][52:37], VEC[i][36:5], VEC[i][1], VEC[i][0]);
        end

        // R9: extreme displacements
        apply(16'hC1FF, 32'h0000_2000, 3'b100);
        chk(out_target == 32'h0000_23FE, "R9 disp 0x1FF", out_target, 32'h0000_23FE);
        chk(out_taken == 1'b1, "R9 taken at max", 32'(out_taken), 32'd1);
        apply(16'hC200, 32'h0000_2000, 3'b100);
        chk(out_target == 32'h0000_1C00, "R9 disp 0x200", out_target, 32'h0000_1C00);

        // R9: wrap below zero while taken
        apply(16'hC7FE, 32'h0000_0002, 3'b000);
        chk(out_target == 32'hFFFF_FFFE, "R9 wrap down", out_target, 32'hFFFF_FFFE);
        chk(out_taken == 1'b1, "R9 taken during wrap", 32'(out_taken), 32'd1);
        // R9: wrap above top, sequential reaches zero
        apply(16'hC004, 32'hFFFF_FFFE, 3'b100);
        chk(out_target == 32'h0000_0006, "R9 wrap up", out_target, 32'h0000_0006);
        chk(out_seq_pc == 32'h0000_0000, "R9 seq wrap", out_seq_pc, 32'h0);

        // R8: changed inputs with valid low leave outputs unchanged
        @(negedge clk);
        instr = 16'hE420; instr_pc = 32'h1234_5678;
        {flag_eq, flag_lt, flag_ltu} = 3'b111;
        repeat (3) @(negedge clk);
        chk(out_target == 32'h0000_0006, "R8 hold target", out_target, 32'h0000_0006);
        chk(out_illegal == 1'b0 && out_taken == 1'b1, "R8 hold flags",
            32'({out_illegal, out_taken}), 32'd1);
        chk(out_seq_pc == 32'h0, "R8 hold seq", out_seq_pc, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule